// File: doc/BRIEF.md
# Configurable UART Transceiver

This block is a full-duplex asynchronous serial transceiver. One control byte, written through a simple write strobe, sets all of its options. It can enable the transmitter and the receiver, gate transmission on a clear-to-send input, add an even or odd parity bit, send one or two stop bits, force a break, and turn the transmit stream back into the receiver.

The transmitter takes bytes from a one-byte holding register. Each frame opens with a low start bit, then carries eight data bits least significant bit first, an optional parity bit and the stop bits. Between frames the line rests high. The receiver runs on a tick at sixteen times the bit rate. It finds a start edge and takes every bit at its midpoint. When it has the first stop bit, it delivers the byte with a one-cycle valid pulse, together with parity-error and framing-error flags.

The oversampling tick comes from an external baud generator. The surrounding logic supplies bytes and consumes results.

Top module: `uart_xcvr`

## Requirements
- R1: After reset the control byte is 0, `txd` is 1, `tx_empty` is 1, and `rx_valid`, `rx_perr` and `rx_ferr` are 0.
- R2: The control byte is written with `ctrl_we`, and its bits are: bit0 transmit enable, bit1 receive enable, bit2 CTS gating, bit3 parity enable, bit4 odd parity, bit5 break, bit6 two stop bits, bit7 loopback.
- R3: A transmitted frame is a 0 start bit, then data bits 0 to 7, then stop bits at 1. Each bit lasts 16 ticks, and the line is 1 when idle.
- R4: With parity enabled, one parity bit follows bit 7. It gives an even count of ones over data plus parity when bit4 is 0, and an odd count when bit4 is 1.
- R5: With bit6 at 0 a frame ends with one stop bit, and with bit6 at 1 it ends with two. Back-to-back frames without parity therefore start 160 or 176 ticks apart.
- R6: A frame starts only while transmit enable is 1 and, when CTS gating is on, `cts_n` is 0. When gating is off, `cts_n` has no effect.
- R7: While break is 1, `txd` is 0 from the cycle after the control write. A frame in progress is dropped and is not resumed after the break is cleared.
- R8: `tx_wr` loads `tx_data` only when the holding register is empty (`tx_empty`=1). A write while it is full is ignored. The register empties when a frame starts.
- R9: The receiver starts a frame on a falling edge of the line. It rejects the start as false if the line is 1 at the middle of the start bit. After that it samples each bit at its middle.
- R10: At the middle of the first stop bit, `rx_valid` pulses for one cycle. `rx_data` and the flags then hold until the next delivery. `rx_perr` is set when parity is enabled and the received parity does not match the selected sense.
- R11: A first stop bit sampled as 0 sets `rx_ferr`, and the byte is still delivered.
- R12: While receive enable is 0, the receiver ignores the line. There is no `rx_valid`, and `rx_data` and the flags keep their values.
- R13: With loopback set, the transmit bit stream drives the receiver and the `rxd` pin is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value |
| tx_wr | input | 1 | Holding register write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register can accept a byte |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse, received byte delivered |
| rx_data | output | 8 | Last received byte |
| rx_perr | output | 1 | Parity error of last byte |
| rx_ferr | output | 1 | Framing error of last byte |

## Verification
A control write shows up on `txd` one clock later. The bench checks break and release at the first falling clock edge after the write. Bit k of a transmitted frame is centred 16k+8 ticks after the start edge, so the bench counts ticks from the observed fall and samples `txd` there. Stop-bit count is checked by counting ticks between two start edges of back-to-back frames. Received results come at the middle of the stop bit, plus a two-clock synchroniser. The bench counts `rx_valid` pulses in a monitor and reads the outputs only after its driven frame and a further idle period have passed. An ignored stimulus is checked by holding the observation window open for tens of ticks afterwards.

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_empty,
  input  logic       cts_n,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_perr,
  output logic       rx_ferr
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam logic [CW-1:0] TC_END = CW'(OVS - 1);
  localparam logic [CW-1:0] TC_MID = CW'(HALF - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

  logic [7:0] ctrl;
  wire c_txen  = ctrl[0];
  wire c_rxen  = ctrl[1];
  wire c_cts   = ctrl[2];
  wire c_pen   = ctrl[3];
  wire c_podd  = ctrl[4];
  wire c_brk   = ctrl[5];
  wire c_stop2 = ctrl[6];
  wire c_loop  = ctrl[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_we) ctrl <= ctrl_wdata;

  // transmitter
  logic [7:0]    hold_q;
  logic          hold_full;
  logic          tx_busy;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_tc;

  wire tx_go  = !tx_busy && hold_full && c_txen && (!c_cts || !cts_n) && !c_brk;
  wire tx_par = ^hold_q ^ c_podd;

  assign tx_empty = !hold_full;
  assign txd      = c_brk ? 1'b0 : (tx_busy ? tx_sh[0] : 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (tx_go) begin
      hold_full <= 1'b0;
    end else if (tx_wr && !hold_full) begin
      hold_q    <= tx_data;
      hold_full <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_tc   <= '0;
    end else if (c_brk) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_tc   <= '0;
    end else if (tx_go) begin
      tx_busy <= 1'b1;
      tx_sh   <= {2'b11, c_pen ? tx_par : 1'b1, hold_q, 1'b0};
      tx_left <= 4'd10 + {3'b000, c_pen} + {3'b000, c_stop2};
      tx_tc   <= '0;
    end else if (tx_busy && tick) begin
      if (tx_tc == TC_END) begin
        tx_tc   <= '0;
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end else begin
        tx_tc <= tx_tc + 1'b1;
      end
    end

  // receiver
  logic          rx_s1, rx_s2;
  logic          line_prev;
  rx_state_t     rx_st;
  logic [CW-1:0] rx_tc;
  logic [2:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic          rx_pbit;

  wire line = c_loop ? txd : rx_s2;
  wire rx_mid_start = tick && (rx_tc == TC_MID);
  wire rx_mid_bit   = tick && (rx_tc == TC_END);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st     <= RX_IDLE;
      rx_tc     <= '0;
      rx_idx    <= '0;
      rx_sh     <= '0;
      rx_pbit   <= 1'b0;
      line_prev <= 1'b1;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_perr   <= 1'b0;
      rx_ferr   <= 1'b0;
    end else if (!c_rxen) begin
      rx_st     <= RX_IDLE;
      rx_tc     <= '0;
      line_prev <= 1'b1;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) line_prev <= line;
      if (tick && rx_st != RX_IDLE)
        rx_tc <= (rx_mid_bit || (rx_st == RX_START && rx_mid_start)) ? '0 : rx_tc + 1'b1;
      unique case (rx_st)
        RX_IDLE:
          if (tick && line_prev && !line) begin
            rx_st <= RX_START;
            rx_tc <= '0;
          end
        RX_START:
          if (rx_mid_start) begin
            rx_st  <= line ? RX_IDLE : RX_DATA;
            rx_idx <= '0;
          end
        RX_DATA:
          if (rx_mid_bit) begin
            rx_sh  <= {line, rx_sh[7:1]};
            rx_idx <= rx_idx + 3'd1;
            if (rx_idx == 3'd7) rx_st <= c_pen ? RX_PAR : RX_STOP;
          end
        RX_PAR:
          if (rx_mid_bit) begin
            rx_pbit <= line;
            rx_st   <= RX_STOP;
          end
        RX_STOP:
          if (rx_mid_bit) begin
            rx_data  <= rx_sh;
            rx_perr  <= c_pen && (^rx_sh ^ rx_pbit ^ c_podd);
            rx_ferr  <= !line;
            rx_valid <= 1'b1;
            rx_st    <= RX_IDLE;
          end
        default: rx_st <= RX_IDLE;
      endcase
    end

  a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(c_txen && (!c_cts || !cts_n)));

  a_r7_break_drops_frame: assert property (@(posedge clk) disable iff (!rst_n)
    c_brk |=> !tx_busy);

  a_r8_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && hold_full) |=> hold_q == $past(hold_q));

  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!c_rxen) |-> !rx_valid);

  a_r3_frame_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && !$past(c_brk)) |-> $past(tick));
endmodule

// File: tb/uart_xcvr_tb.sv
module uart_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_empty;
  logic       cts_n = 1'b1;
  logic       txd;
  logic       rxd = 1'b1;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_perr, rx_ferr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tdiv = 0;
  int rx_cnt = 0;
  logic [7:0] cap_data;
  logic cap_perr, cap_ferr;

  uart_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
    .cts_n(cts_n), .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  always @(negedge clk)
    if (rst_n && rx_valid) begin
      rx_cnt = rx_cnt + 1;
      cap_data = rx_data;
      cap_perr = rx_perr;
      cap_ferr = rx_ferr;
    end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic write_tx(input logic [7:0] v);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = v;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  function automatic logic [11:0] frame_of(input logic [7:0] d, input logic pen, input logic podd);
    logic [11:0] f;
    f = 12'hFFF;
    f[0] = 1'b0;
    f[8:1] = d;
    if (pen) f[9] = ^d ^ podd;
    return f;
  endfunction

  task automatic capture_tx(input int n, output logic [11:0] bits, output logic ok);
    int t;
    t = 0;
    bits = 12'hFFF;
    ok = 1'b1;
    @(negedge clk);
    while (txd !== 1'b0 && t < 6000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 6000) ok = 1'b0;
    else begin
      wait_ticks(8);
      bits[0] = txd;
      for (int k = 1; k < n; k++) begin
        wait_ticks(16);
        bits[k] = txd;
      end
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input logic pen, input logic podd,
                         input logic bad_par, input logic bad_stop);
    @(negedge clk);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (pen) begin
      rxd = ^d ^ podd ^ bad_par;
      wait_ticks(16);
    end
    rxd = !bad_stop;
    wait_ticks(16);
    rxd = 1'b1;
    wait_ticks(24);
  endtask

  // ctrl, tx byte, rx byte, bad parity, bad stop
  localparam logic [25:0] VEC [7] = '{
    {8'h03, 8'hA5, 8'h3C, 2'b00},
    {8'h0B, 8'h5A, 8'h81, 2'b00},
    {8'h1B, 8'h01, 8'hFE, 2'b00},
    {8'h4B, 8'hC3, 8'h7E, 2'b00},
    {8'h0B, 8'h00, 8'h55, 2'b10},
    {8'h03, 8'hFF, 8'h96, 2'b01},
    {8'h1B, 8'h80, 8'h11, 2'b11}
  };

  logic [11:0] fr;
  logic        ok;
  int          cnt0;
  int          tks;
  logic        seen_low;
  logic [7:0]  keep_d;
  logic        keep_p, keep_f;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd idle", txd, 1);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx_perr", rx_perr, 0);
    check("R1 rx_ferr", rx_ferr, 0);

    // R2 R3 R4 R10 R11: table-driven full-duplex frames
    foreach (VEC[i]) begin
      logic [7:0] c, tb, rb;
      logic bp, bs;
      int n;
      {c, tb, rb, bp, bs} = VEC[i];
      n = 10 + int'(c[3]) + int'(c[6]);
      write_ctrl(c);
      write_tx(tb);
      cnt0 = rx_cnt;
      fork
        capture_tx(n, fr, ok);
        send_rx(rb, c[3], c[4], bp, bs);
      join
      check("R2/R3 tx frame started", ok, 1);
      check("R3 tx frame bits", fr, frame_of(tb, c[3], c[4]));
      if (c[3]) check("R4 tx parity bit", fr[9], ^tb ^ c[4]);
      check("R5 tx stop bit level", fr[n-1], 1);
      check("R10 one delivery", rx_cnt - cnt0, 1);
      check("R10 rx data", cap_data, rb);
      check("R10 rx parity flag", cap_perr, bp & c[3]);
      check("R11 rx framing flag", cap_ferr, bs);
    end

    // R12: receiver disabled keeps old results
    keep_d = rx_data; keep_p = rx_perr; keep_f = rx_ferr;
    write_ctrl(8'h00);
    cnt0 = rx_cnt;
    send_rx(8'h4D, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R12 no delivery when disabled", rx_cnt - cnt0, 0);
    check("R12 data held", rx_data, keep_d);
    check("R12 perr held", rx_perr, keep_p);
    check("R12 ferr held", rx_ferr, keep_f);

    // R9: false start rejected, then a clean frame
    write_ctrl(8'h02);
    cnt0 = rx_cnt;
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(40);
    check("R9 false start ignored", rx_cnt - cnt0, 0);
    send_rx(8'h6B, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 frame after false start", rx_cnt - cnt0, 1);
    check("R9 mid-bit sampled data", cap_data, 8'h6B);

    // R8 and R6: transmit disabled, second write while full
    write_ctrl(8'h00);
    write_tx(8'h11);
    check("R8 holding full", tx_empty, 0);
    write_tx(8'h22);
    seen_low = 1'b0;
    repeat (160) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    check("R6 no frame while disabled", seen_low, 0);
    write_ctrl(8'h01);
    capture_tx(10, fr, ok);
    check("R8 first byte kept", fr, frame_of(8'h11, 1'b0, 1'b0));
    check("R8 holding emptied at start", tx_empty, 1);
    wait_ticks(16);

    // R6: CTS gating
    write_ctrl(8'h05);
    cts_n = 1'b1;
    write_tx(8'h3C);
    seen_low = 1'b0;
    repeat (160) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    check("R6 held by cts_n high", seen_low, 0);
    check("R6 byte still waiting", tx_empty, 0);
    cts_n = 1'b0;
    capture_tx(10, fr, ok);
    check("R6 sent after cts_n low", fr, frame_of(8'h3C, 1'b0, 1'b0));
    wait_ticks(16);
    write_ctrl(8'h01);
    cts_n = 1'b1;
    write_tx(8'h96);
    capture_tx(10, fr, ok);
    check("R6 cts_n ignored when gating off", fr, frame_of(8'h96, 1'b0, 1'b0));
    wait_ticks(16);

    // R5: start-to-start spacing for one and two stop bits
    for (int s = 0; s < 2; s++) begin
      write_ctrl(s == 1 ? 8'h41 : 8'h01);
      write_tx(8'hFF);
      while (txd !== 1'b0) @(negedge clk);
      write_tx(8'hFF);
      tks = 0;
      do begin
        @(posedge clk); if (tick) tks++;
        @(negedge clk);
      end while (txd === 1'b0);
      do begin
        @(posedge clk); if (tick) tks++;
        @(negedge clk);
      end while (txd === 1'b1 && tks < 400);
      check("R5 frame spacing in ticks", tks, s == 1 ? 176 : 160);
      wait_ticks(200);
    end

    // R7: break cuts a frame
    write_ctrl(8'h01);
    write_tx(8'hFF);
    while (txd !== 1'b0) @(negedge clk);
    wait_ticks(40);
    write_ctrl(8'h21);
    check("R7 break forces low", txd, 0);
    wait_ticks(50);
    check("R7 break holds low", txd, 0);
    write_ctrl(8'h01);
    check("R7 line high after break", txd, 1);
    seen_low = 1'b0;
    repeat (800) begin
      @(negedge clk);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    check("R7 frame not resumed", seen_low, 0);

    // R13: loopback, rxd pin held low
    rxd = 1'b0;
    write_ctrl(8'h83);
    cnt0 = rx_cnt;
    write_tx(8'hC5);
    tks = 0;
    while (rx_cnt == cnt0 && tks < 4000) begin
      @(negedge clk);
      tks++;
    end
    check("R13 loopback delivered", rx_cnt - cnt0, 1);
    check("R13 loopback data", cap_data, 8'hC5);
    check("R13 loopback framing", cap_ferr, 0);
    write_ctrl(8'h00);
    rxd = 1'b1;
    wait_ticks(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule